// File: doc/BRIEF.md
# Double-Buffered Serial Port

This block is a full-duplex serial port in which each direction sits behind a CPU-visible register. On the transmit side a word written into a holding register waits there until the shift register is free. It is then moved into the shift register and sent most-significant bit first, one bit for each transmit bit-clock enable. A ready flag and an interrupt request tell the CPU that the holding register can take the next word. On the receive side, bits sampled on the receive bit-clock enable collect into a word. Each finished word passes through an intermediate buffer into a data register, and the data register raises a ready flag and an interrupt until the CPU reads it.

Both data paths follow valid/ready conventions. On transmit, `tx_rdy` is the ready signal and `tx_wr` is the valid strobe. A write made while `tx_rdy` is low is not stalled: it replaces the pending word and leaves a sticky mark in `tx_ovw`. On receive, `rx_rdy` is the valid signal and `rx_rd` is the consumer's acknowledge. When the consumer stalls, up to two words wait (data register plus buffer), and any further word is discarded and flagged in `rx_ovr`. In stereo audio use, the right sample goes in the upper half of the word and the left sample in the lower half, so the right sample leaves the wire first.

Top module: `dbuf_serial_port`

## Requirements
- R1: After reset, `tx_rdy` and `tx_irq` are 1, `rx_rdy` and `rx_irq` are 0, `tx_sd` is 0, and both sticky flags are 0.
- R2: A clock edge with `tx_wr` high loads `tx_wdata` into the holding register and drives `tx_rdy` low from the next cycle.
- R3: On a `tx_bit_en` edge where the holding register is full and the shifter is either idle or on its final bit, the held word moves into the shifter and `tx_rdy` rises. `tx_irq` equals `tx_rdy` at all times.
- R4: The shifter drives bit 31 on `tx_sd` first, after the loading edge. It advances one bit on each later `tx_bit_en` edge, and `tx_sd` does not change on cycles without `tx_bit_en`. Consecutive words leave no gap. An idle shifter drives `tx_sd` to 0.
- R5: A stereo word packed with the right sample in bits 31:16 and the left sample in bits 15:0 sends all 16 right-sample bits before any left-sample bit.
- R6: A write while `tx_rdy` is low replaces the pending word, so only the newer word is transmitted. It also sets `tx_ovw`, which stays 1 until reset.
- R7: On each `rx_bit_en` edge, `rx_sd` is shifted in, and the first bit of a word is its bit 31. The edge that takes the 32nd bit places the word in the buffer. If the data register is empty, the word moves there on the following edge, and only then do `rx_rdy` and `rx_irq` rise.
- R8: A clock edge with `rx_rd` high while `rx_rdy` is 1 empties the data register, so `rx_rdy` is 0 in the next cycle. A word waiting in the buffer moves up one edge later.
- R9: A word that completes while both the buffer and the data register hold words is discarded and sets `rx_ovr`, which stays 1 until reset. The two held words are delivered unchanged.
- R10: While `rx_rdy` is 1 and `rx_rd` is 0, `rx_rdata` and `rx_rdy` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit_en | input | 1 | Transmit bit-clock enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | WORD_W | Word to transmit |
| tx_sd | output | 1 | Serial transmit data |
| tx_rdy | output | 1 | Holding register empty |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_ovw | output | 1 | Sticky: a pending word was overwritten |
| rx_bit_en | input | 1 | Receive bit-clock enable |
| rx_sd | input | 1 | Serial receive data |
| rx_rd | input | 1 | Read strobe for the receive data register |
| rx_rdata | output | WORD_W | Received word |
| rx_rdy | output | 1 | Receive data register full |
| rx_irq | output | 1 | Receive interrupt request |
| rx_ovr | output | 1 | Sticky: a received word was discarded |

## Verification
The bench overwrites a pending word while another word is shifting out. A design that let the older word through, or that flagged an overwrite when the write met the load edge, would be caught there. It writes each new word right after the previous load, so a one-bit gap between words shows up as a shifted word, and a stereo word with distinct halves exposes a reversed bit order. On receive, it checks the extra cycle through the buffer and the drop of a third unread word. A design that overwrote the data register or the buffer on overrun, or that raised `rx_rdy` too early, would fail.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  typedef enum logic {SH_IDLE, SH_BUSY} sh_state_e;
endpackage

// File: rtl/dbsp_tx.sv
module dbsp_tx
  import dbsp_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              sd,
  output logic              rdy,
  output logic              ovw
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic              hold_full;
  logic [CNT_W-1:0]  cnt_q;
  sh_state_e         st_q;
  logic              at_end, do_load;

  assign at_end  = (st_q == SH_BUSY) && (cnt_q == LAST);
  assign do_load = bit_en && hold_full && ((st_q == SH_IDLE) || at_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      sh_q      <= '0;
      hold_full <= 1'b0;
      cnt_q     <= '0;
      st_q      <= SH_IDLE;
      ovw       <= 1'b0;
    end else begin
      if (bit_en) begin
        if (do_load) begin
          sh_q  <= hold_q;
          cnt_q <= '0;
          st_q  <= SH_BUSY;
        end else if (at_end) begin
          st_q <= SH_IDLE;
        end else if (st_q == SH_BUSY) begin
          sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
        if (hold_full && !do_load) ovw <= 1'b1;
      end else if (do_load) begin
        hold_full <= 1'b0;
      end
    end
  end

  assign sd  = (st_q == SH_BUSY) ? sh_q[WORD_W-1] : 1'b0;
  assign rdy = !hold_full;
endmodule

// File: rtl/dbsp_rx.sv
module dbsp_rx
  import dbsp_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              sd,
  input  logic              rd,
  output logic [WORD_W-1:0] data,
  output logic              rdy,
  output logic              ovr
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] mid_q, dat_q;
  logic              mid_full, dat_full;
  logic [WORD_W-1:0] new_word;
  logic              word_done, mid_move;

  assign new_word  = {sh_q, sd};
  assign word_done = bit_en && (cnt_q == LAST);
  assign mid_move  = mid_full && !dat_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      mid_q    <= '0;
      dat_q    <= '0;
      mid_full <= 1'b0;
      dat_full <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (bit_en) begin
        sh_q  <= new_word[WORD_W-2:0];
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (mid_move) begin
        dat_q    <= mid_q;
        dat_full <= 1'b1;
      end else if (rd && dat_full) begin
        dat_full <= 1'b0;
      end
      if (word_done) begin
        if (!mid_full || mid_move) begin
          mid_q    <= new_word;
          mid_full <= 1'b1;
        end else begin
          ovr <= 1'b1;
        end
      end else if (mid_move) begin
        mid_full <= 1'b0;
      end
    end
  end

  assign data = dat_q;
  assign rdy  = dat_full;
endmodule

// File: rtl/dbuf_serial_port.sv
module dbuf_serial_port
  import dbsp_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bit_en,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_wdata,
  output logic              tx_sd,
  output logic              tx_rdy,
  output logic              tx_irq,
  output logic              tx_ovw,
  input  logic              rx_bit_en,
  input  logic              rx_sd,
  input  logic              rx_rd,
  output logic [WORD_W-1:0] rx_rdata,
  output logic              rx_rdy,
  output logic              rx_irq,
  output logic              rx_ovr
);
  dbsp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .wr(tx_wr),
    .wr_data(tx_wdata), .sd(tx_sd), .rdy(tx_rdy), .ovw(tx_ovw)
  );

  dbsp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .sd(rx_sd),
    .rd(rx_rd), .data(rx_rdata), .rdy(rx_rdy), .ovr(rx_ovr)
  );

  assign tx_irq = tx_rdy;
  assign rx_irq = rx_rdy;
endmodule

// File: rtl/dbsp_chk.sv
module dbsp_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_bit_en,
  input logic              tx_wr,
  input logic              tx_sd,
  input logic              tx_rdy,
  input logic              tx_ovw,
  input logic              rx_rd,
  input logic [WORD_W-1:0] rx_rdata,
  input logic              rx_rdy,
  input logic              rx_ovr
);
  AST_TX_WR_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_rdy); // R2
  AST_TX_SD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_en |=> $stable(tx_sd)); // R4
  AST_TX_OVW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovw |=> tx_ovw); // R6
  AST_RX_RD_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_rdy) |=> !rx_rdy); // R8
  AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> rx_ovr); // R9
  AST_RX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rdy && !rx_rd) |=> (rx_rdy && $stable(rx_rdata))); // R10
endmodule

bind dbuf_serial_port dbsp_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_bit_en(tx_bit_en), .tx_wr(tx_wr),
  .tx_sd(tx_sd), .tx_rdy(tx_rdy), .tx_ovw(tx_ovw), .rx_rd(rx_rd),
  .rx_rdata(rx_rdata), .rx_rdy(rx_rdy), .rx_ovr(rx_ovr)
);

// File: tb/dbuf_serial_port_tb.sv
`timescale 1ns/1ps
module dbuf_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        tx_bit_en = 1'b0, tx_wr = 1'b0, rx_bit_en = 1'b0, rx_sd = 1'b0, rx_rd = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_sd, tx_rdy, tx_irq, tx_ovw, rx_rdy, rx_irq, rx_ovr;
  logic [31:0] rx_rdata;

  dbuf_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .tx_bit_en(tx_bit_en), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_sd(tx_sd), .tx_rdy(tx_rdy), .tx_irq(tx_irq),
    .tx_ovw(tx_ovw), .rx_bit_en(rx_bit_en), .rx_sd(rx_sd), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_rdy(rx_rdy), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
  );

  int checks = 0, errors = 0, tx_seen = 0;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];
  bit rx_auto = 1'b0;
  logic [1:0] div = '0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // transmit bit-clock enable: one edge in four
  always @(negedge clk) begin
    if (!rst_n) begin
      div <= '0;
      tx_bit_en <= 1'b0;
    end else begin
      div <= div + 1'b1;
      tx_bit_en <= (div == 2'd3);
    end
  end

  // driver: transmit write, pushes the expected word
  task automatic tx_write(input logic [31:0] w, input bit replace);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_wdata = w;
    if (replace) tx_q[tx_q.size()-1] = w;
    else tx_q.push_back(w);
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_rdy == 1'b0, "R2 tx_rdy low after write", 32'(tx_rdy), 32'd0);
  endtask

  task automatic wait_tx_rdy(input int limit);
    int n = 0;
    while (!tx_rdy && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(tx_rdy == 1'b1, "R3 tx_rdy returns after load", 32'(tx_rdy), 32'd1);
    chk(tx_irq == 1'b1, "R3 tx_irq with tx_rdy", 32'(tx_irq), 32'd1);
  endtask

  // monitor: rebuilds each transmitted word and compares it with the queue
  initial begin
    wait (rst_n);
    forever begin
      logic [31:0] got, exp;
      wait (tx_q.size() != 0);
      @(posedge clk);
      for (int i = 31; i >= 0; i--) begin
        do @(posedge clk); while (!tx_bit_en);
        @(negedge clk);
        got[i] = tx_sd;
      end
      exp = tx_q.pop_front();
      chk(got == exp, "R4 R5 R6 transmitted word", got, exp);
      tx_seen++;
    end
  end

  // driver: serial receive word
  task automatic rx_send(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      rx_sd = w[i];
      rx_bit_en = 1'b1;
      @(negedge clk);
      rx_bit_en = 1'b0;
    end
  endtask

  // monitor: consumes received words when enabled
  initial begin
    forever begin
      logic [31:0] exp;
      @(negedge clk);
      if (rx_auto && rx_rdy && !rx_rd) begin
        if (rx_q.size() == 0) begin
          chk(1'b0, "R9 unexpected received word", rx_rdata, 32'd0);
        end else begin
          exp = rx_q.pop_front();
          chk(rx_rdata == exp, "R7 R9 received word", rx_rdata, exp);
        end
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_rdy == 1'b0, "R8 rx_rdy clears on read", 32'(rx_rdy), 32'd0);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_rdy == 1'b1, "R1 tx_rdy after reset", 32'(tx_rdy), 32'd1);
    chk(tx_irq == 1'b1, "R1 tx_irq after reset", 32'(tx_irq), 32'd1);
    chk(rx_rdy == 1'b0, "R1 rx_rdy after reset", 32'(rx_rdy), 32'd0);
    chk(rx_irq == 1'b0, "R1 rx_irq after reset", 32'(rx_irq), 32'd0);
    chk(tx_sd == 1'b0, "R1 tx_sd after reset", 32'(tx_sd), 32'd0);
    chk({tx_ovw, rx_ovr} == 2'b00, "R1 sticky flags after reset", 32'({tx_ovw, rx_ovr}), 32'd0);

    // transmit: first word, then an overwritten pending word, then a stereo word
    tx_write(32'hC0DE_5A96, 1'b0);
    chk(tx_irq == 1'b0, "R3 tx_irq low while holding full", 32'(tx_irq), 32'd0);
    wait_tx_rdy(20);
    chk(tx_ovw == 1'b0, "R6 no overwrite flag yet", 32'(tx_ovw), 32'd0);
    tx_write(32'h1111_2222, 1'b0);
    tx_write(32'h8E37_F00D, 1'b1);
    chk(tx_ovw == 1'b1, "R6 overwrite flag set", 32'(tx_ovw), 32'd1);
    wait_tx_rdy(300);
    tx_write({16'hA5C3, 16'h1234}, 1'b0);
    wait_tx_rdy(300);
    begin
      int n = 0;
      while (tx_seen < 3 && n < 1000) begin
        @(negedge clk);
        n++;
      end
    end
    chk(tx_seen == 3, "R4 all words transmitted", 32'(tx_seen), 32'd3);
    repeat (8) @(negedge clk);
    chk(tx_sd == 1'b0, "R4 idle line low", 32'(tx_sd), 32'd0);
    chk(tx_ovw == 1'b1, "R6 overwrite flag sticky", 32'(tx_ovw), 32'd1);

    // receive: pipeline timing of one word
    rx_send(32'h9ABC_DEF1);
    chk(rx_rdy == 1'b0, "R7 word still in buffer", 32'(rx_rdy), 32'd0);
    @(negedge clk);
    chk(rx_rdy == 1'b1, "R7 rx_rdy one edge later", 32'(rx_rdy), 32'd1);
    chk(rx_irq == 1'b1, "R7 rx_irq with rx_rdy", 32'(rx_irq), 32'd1);
    rx_q.push_back(32'h9ABC_DEF1);
    rx_auto = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_q.size() == 0, "R8 word consumed", 32'(rx_q.size()), 32'd0);
    rx_auto = 1'b0;

    // receive: overrun with a stalled consumer
    rx_send(32'h0F0F_3C3C);
    rx_q.push_back(32'h0F0F_3C3C);
    rx_send(32'hDEAD_0001);
    rx_q.push_back(32'hDEAD_0001);
    chk(rx_ovr == 1'b0, "R9 no overrun with two held", 32'(rx_ovr), 32'd0);
    rx_send(32'h7777_AAAA);
    repeat (2) @(negedge clk);
    chk(rx_ovr == 1'b1, "R9 overrun flag set", 32'(rx_ovr), 32'd1);
    chk(rx_rdata == 32'h0F0F_3C3C, "R10 data register unchanged", rx_rdata, 32'h0F0F_3C3C);
    rx_auto = 1'b1;
    repeat (12) @(negedge clk);
    chk(rx_q.size() == 0, "R9 held words delivered", 32'(rx_q.size()), 32'd0);
    chk(rx_rdy == 1'b0, "R9 dropped word absent", 32'(rx_rdy), 32'd0);
    chk(rx_ovr == 1'b1, "R9 overrun flag sticky", 32'(rx_ovr), 32'd1);
    finish_run();
  end
endmodule